// File: doc/BRIEF.md
# Mode-Switchable Branch Direction Predictor

This block predicts whether a conditional branch is taken for a small four-stage in-order core. A two-bit mode register, written by software through a dedicated write port, selects the behaviour.

In the high-performance modes the prediction comes from a table of two-bit saturating counters. The table is indexed by the fetch address field XORed with a global record of recent branch outcomes. In the normal and low-power modes the table and the history are gated off: they neither update nor toggle, and every branch is predicted not taken.

The fetch stage presents the PC index field, which is PC bits [9:2], and reads the prediction in the same cycle. The execute stage reports each resolved branch with its PC index field and its actual outcome.

Top module: `mode_bpred`

## Requirements
- R1: After reset the mode register holds 2'b10 (high-performance), every counter holds 2'b01 (weakly not taken) and the history is zero, so `predict_taken` is 0 for every lookup index.
- R2: The mode register is encoded as 2'b00 = low-power, 2'b01 = normal, 2'b10 = high-performance, 2'b11 = high-performance. A write with `mode_wr_en` high loads `mode_wr_data` at the clock edge, and `mode_o` shows it from that edge on.
- R3: In a high-performance mode, `predict_taken` combinationally equals bit 1 of the counter at index `lookup_pc ^ history`.
- R4: In low-power (2'b00) and normal (2'b01) modes, `predict_taken` is 0 for every lookup.
- R5: In a high-performance mode, a cycle with `resolve_valid` high updates the counter at index `resolve_pc ^ history`, using the history before that edge. A taken outcome increments the counter, saturating at 2'b11. A not-taken outcome decrements it, saturating at 2'b00.
- R6: In a high-performance mode, each resolved branch shifts the history left by one bit and puts the actual outcome (1 = taken) into bit 0.
- R7: In low-power and normal modes, resolved branches change neither the counters nor the history.
- R8: A write that moves the mode from a non-high-performance value to a high-performance value clears the history to zero at that edge. The counters keep their contents.
- R9: `table_en` is 1 exactly while the mode register holds a high-performance value.
- R10: A resolve in the same cycle as a mode write is handled under the mode held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr_en | input | 1 | Software write strobe for the mode register |
| mode_wr_data | input | 2 | New mode value |
| mode_o | output | 2 | Current mode register value |
| lookup_pc | input | HIST_W | Fetch PC index field (PC bits [9:2]) |
| predict_taken | output | 1 | Predicted direction for the lookup, 1 = taken |
| resolve_valid | input | 1 | A resolved branch is reported this cycle |
| resolve_pc | input | HIST_W | PC index field of the resolved branch |
| resolve_taken | input | 1 | Actual outcome of the resolved branch |
| table_en | output | 1 | Enable of the counter table and history (gating) |

## Verification
The prediction is combinational, so it is due in the same cycle as the lookup index. It reflects every counter and history change from earlier edges. Mode writes, counter updates and history shifts take effect at the next rising edge, so `mode_o`, `table_en` and the predictions that depend on them change one edge after the stimulus.

The bench drives inputs on the falling edge and samples the outputs 1 ns later. It advances its own model of the mode, counters and history only after the following rising edge. Each comparison therefore sees exactly the state built from earlier edges.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

  typedef enum logic [1:0] {
    MODE_LOWPWR = 2'b00,
    MODE_NORMAL = 2'b01,
    MODE_PERF   = 2'b10,
    MODE_PERF_X = 2'b11
  } bpred_mode_e;

  localparam logic [1:0] CTR_INIT = 2'b01;

  // Both high-performance encodings have bit 1 set
  function automatic logic mode_is_perf(input logic [1:0] m);
    return m[1];
  endfunction

  // Two-bit saturating counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    n = c;
    if (taken && c != 2'b11) n = c + 2'b01;
    else if (!taken && c != 2'b00) n = c - 2'b01;
    return n;
  endfunction

endpackage

// File: rtl/bpred_mode_reg.sv
module bpred_mode_reg
  import bpred_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] mode_q,
  output logic       perf_on,
  output logic       enter_perf
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_PERF;
    else if (wr_en) mode_q <= wr_data;
  end

  assign perf_on    = mode_is_perf(mode_q);
  assign enter_perf = wr_en && mode_is_perf(wr_data) && !perf_on;

endmodule

// File: rtl/bpred_ghr.sv
module bpred_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else if (clr) hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/bpred_pht.sv
module bpred_pht
  import bpred_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ctr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (en && wr_req) begin
      ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

endmodule

// File: rtl/mode_bpred.sv
module mode_bpred
  import bpred_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_en,
  input  logic [1:0]        mode_wr_data,
  output logic [1:0]        mode_o,
  input  logic [HIST_W-1:0] lookup_pc,
  output logic              predict_taken,
  input  logic              resolve_valid,
  input  logic [HIST_W-1:0] resolve_pc,
  input  logic              resolve_taken,
  output logic              table_en
);

  localparam int IDX_W = HIST_W;

  logic              perf_on;
  logic              enter_perf;
  logic [HIST_W-1:0] hist_w;
  logic [1:0]        rd_ctr;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              upd_fire;

  bpred_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (mode_wr_en),
    .wr_data    (mode_wr_data),
    .mode_q     (mode_o),
    .perf_on    (perf_on),
    .enter_perf (enter_perf)
  );

  assign upd_fire = perf_on && resolve_valid;
  assign rd_idx   = lookup_pc ^ hist_w;
  assign wr_idx   = resolve_pc ^ hist_w;

  bpred_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (enter_perf),
    .shift_en (upd_fire),
    .bit_in   (resolve_taken),
    .hist_o   (hist_w)
  );

  bpred_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (perf_on),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_req   (resolve_valid),
    .wr_idx   (wr_idx),
    .wr_taken (resolve_taken)
  );

  assign table_en      = perf_on;
  assign predict_taken = perf_on && rd_ctr[1];

endmodule

// File: rtl/mode_bpred_chk.sv
module mode_bpred_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr_en,
  input logic [1:0]        mode_wr_data,
  input logic [1:0]        mode_o,
  input logic              predict_taken,
  input logic              resolve_valid,
  input logic              resolve_taken,
  input logic              table_en,
  input logic              enter_perf,
  input logic [HIST_W-1:0] hist
);

  // R2
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> mode_o == $past(mode_wr_data));

  // R4
  a_r4_off_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_o[1] |-> !predict_taken);

  // R6
  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (table_en && resolve_valid) |=>
      hist == {$past(hist[HIST_W-2:0]), $past(resolve_taken)});

  // R7
  a_r7_hist_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o[1] && !enter_perf) |=> $stable(hist));

  // R8
  a_r8_hist_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    enter_perf |=> hist == '0);

  // R9
  a_r9_gate_off_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
    !table_en |-> !predict_taken);

endmodule

bind mode_bpred mode_bpred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_wr_en    (mode_wr_en),
  .mode_wr_data  (mode_wr_data),
  .mode_o        (mode_o),
  .predict_taken (predict_taken),
  .resolve_valid (resolve_valid),
  .resolve_taken (resolve_taken),
  .table_en      (table_en),
  .enter_perf    (enter_perf),
  .hist          (hist_w)
);

// File: tb/mode_bpred_bench.sv
`timescale 1ns/1ps
module mode_bpred_bench;

  localparam int HW = 8;
  localparam int N  = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr_en = 1'b0;
  logic [1:0]    mode_wr_data = 2'b00;
  logic [1:0]    mode_o;
  logic [HW-1:0] lookup_pc = '0;
  logic          predict_taken;
  logic          resolve_valid = 1'b0;
  logic [HW-1:0] resolve_pc = '0;
  logic          resolve_taken = 1'b0;
  logic          table_en;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [1:0]    m_mode;
  logic [1:0]    m_ctr [N];
  logic [HW-1:0] m_hist;

  always #4 clk = ~clk;

  mode_bpred #(.HIST_W(HW)) u_mode_bpred (
    .clk(clk), .rst_n(rst_n), .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .mode_o(mode_o), .lookup_pc(lookup_pc), .predict_taken(predict_taken),
    .resolve_valid(resolve_valid), .resolve_pc(resolve_pc),
    .resolve_taken(resolve_taken), .table_en(table_en)
  );

  function automatic logic perf(input logic [1:0] m);
    return (m == 2'b10) || (m == 2'b11);
  endfunction

  function automatic logic exp_pred(input logic [HW-1:0] pc);
    if (!perf(m_mode)) return 1'b0;
    return m_ctr[pc ^ m_hist] >= 2'd2;
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive, check combinational outputs, advance model after the edge
  task automatic cyc(input logic we, input logic [1:0] wd, input logic [HW-1:0] lpc,
                     input logic rv, input logic [HW-1:0] rpc, input logic rt,
                     input string tag);
    logic was_perf;
    @(negedge clk);
    mode_wr_en = we; mode_wr_data = wd; lookup_pc = lpc;
    resolve_valid = rv; resolve_pc = rpc; resolve_taken = rt;
    #1;
    check(tag, {7'd0, predict_taken}, {7'd0, exp_pred(lpc)});
    check("R2", {6'd0, mode_o}, {6'd0, m_mode});
    check("R9", {7'd0, table_en}, {7'd0, perf(m_mode)});
    @(posedge clk);
    was_perf = perf(m_mode);
    if (rv && was_perf) begin
      m_ctr[rpc ^ m_hist] = bump(m_ctr[rpc ^ m_hist], rt);
      m_hist = {m_hist[HW-2:0], rt};
    end
    if (we) begin
      if (perf(wd) && !was_perf) m_hist = '0;
      m_mode = wd;
    end
  endtask

  task automatic idle(input logic [HW-1:0] lpc, input string tag);
    cyc(1'b0, 2'b00, lpc, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic setmode(input logic [1:0] m);
    cyc(1'b1, m, '0, 1'b0, '0, 1'b0, "R2");
  endtask

  // resolve aimed at a given counter index under the current model history
  task automatic hit(input logic [HW-1:0] target, input logic t, input string tag);
    cyc(1'b0, 2'b00, target ^ m_hist, 1'b1, target ^ m_hist, t, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [HW-1:0] tgt;
    int unsigned seed;
    void'($urandom(32'd1234));
    m_mode = 2'b10; m_hist = '0;
    for (int i = 0; i < N; i++) m_ctr[i] = 2'b01;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 6; i++) idle(HW'(i * 43), "R1");

    // R5: saturation up and back down on one counter
    tgt = 8'h5a;
    for (int i = 0; i < 4; i++) hit(tgt, 1'b1, "R5");
    idle(tgt ^ m_hist, "R5");
    hit(tgt, 1'b0, "R5");
    idle(tgt ^ m_hist, "R5");
    for (int i = 0; i < 4; i++) hit(tgt, 1'b0, "R5");
    idle(tgt ^ m_hist, "R5");

    // R6: history shifting seen through predictions
    for (int i = 0; i < 8; i++) hit(8'h33, i[0], "R6");
    for (int i = 0; i < 4; i++) idle(HW'(i * 61), "R6");

    // train a counter to taken, then turn prediction off: R4, R7
    for (int i = 0; i < 3; i++) hit(8'hc3, 1'b1, "R3");
    setmode(2'b01);
    for (int i = 0; i < 6; i++) hit(8'hc3, 1'b0, "R7");
    idle(8'hc3, "R4");
    setmode(2'b00);
    for (int i = 0; i < 4; i++) hit(8'h11, 1'b1, "R7");
    idle(8'h11, "R4");

    // R8: back to high-performance clears history, counters kept
    setmode(2'b11);
    idle(8'hc3, "R8");
    idle(8'h11, "R8");
    idle(8'h5a, "R8");

    // R10: resolve alongside mode writes
    cyc(1'b1, 2'b01, 8'h00, 1'b1, 8'h77 ^ m_hist, 1'b1, "R10");
    cyc(1'b1, 2'b10, 8'h00, 1'b1, 8'h78, 1'b1, "R10");
    idle(8'h77, "R10");
    idle(8'h78, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [1:0] wd;
      seed = $urandom;
      we = ($urandom_range(0, 31) == 0);
      wd = 2'($urandom_range(0, 3));
      cyc(we, wd, HW'($urandom_range(0, N - 1)), ($urandom_range(0, 2) != 0),
          HW'($urandom_range(0, 15)), seed[3], perf(m_mode) ? "R3" : "R4");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule